// File: doc/BRIEF.md
# Digital IQ Mixer with Table-Driven Local Oscillator

This block brings a real intermediate-frequency sample stream down to baseband. Each incoming 6-bit sample is multiplied by a cosine value to form the in-phase (I) output and by a sine value to form the quadrature (Q) output. A numerically controlled oscillator supplies both values. It consists of a 24-bit phase accumulator stepped by a programmable increment, followed by a quarter-wave-symmetric sine table.

A single configuration bit negates the Q product. This lets the receiver follow either rotation convention of a QPSK transmitter, which is the same as exchanging I and Q. The block leaves the fourfold phase ambiguity of QPSK alone, and the frame synchroniser further down the chain resolves it. Carrier tracking and filtering also belong to other blocks.

Top module: `iq_mixer`

## Requirements
- R1: The input sample is offset-binary. Code c in 0..63 stands for the signed value c-32, so code 32 is zero, code 0 is -32 and code 63 is +31.
- R2: `out_i` equals the signed sample times the cosine value for the sample's phase, as a 14-bit two's-complement number.
- R3: When `q_negate` is 0, `out_q` equals the signed sample times the sine value for the sample's phase, as a 14-bit two's-complement number.
- R4: When `q_negate` is 1 alongside a sample, `out_q` is the two's-complement negation of the product from R3, and `out_i` is unchanged.
- R5: The 24-bit phase advances by `phase_inc` only on a cycle with `in_valid` high. Cycles with `in_valid` low leave the phase untouched, whatever `phase_inc` holds.
- R6: The phase wraps modulo 2^24.
- R7: A sample uses the phase value from before its own increment. The first sample after reset therefore uses phase 0, which gives sine value 2 and cosine value 127.
- R8: The table address a is the phase's top 8 bits. The sine value is round(127*sin(2*pi*(a+0.5)/256)). The cosine value is the sine value at address (a+64) mod 256.
- R9: `out_valid` is `in_valid` delayed by exactly two clocks, with `out_i` and `out_q` belonging to the same sample. Both outputs hold their values when no new sample reaches them.
- R10: A synchronous reset (`rst` high at a clock edge) clears the phase to 0, drops `out_valid`, and zeroes both products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 6 | Offset-binary IF sample |
| phase_inc | input | 24 | Oscillator phase increment per sample |
| q_negate | input | 1 | Negate the Q product for the sample presented with it |
| out_valid | output | 1 | Product strobe, two clocks after in_valid |
| out_i | output | 14 | Signed in-phase product |
| out_q | output | 14 | Signed quadrature product |

## Verification
The checker assumes that `in_valid`, `in_sample`, `phase_inc` and `q_negate` are driven to known values on every clock once reset is low. It also takes as given that reset lasts at least two clocks, so that no sample entered before reset is still in the pipeline. The bench drives every input at the falling edge and keeps them defined at all times. It holds reset for several cycles, including with the strobe high. During idle gaps it changes `phase_inc` on purpose, so that the accumulator-hold property is tested against inputs that would move the phase.

// File: rtl/iq_mixer_pkg.sv
package iq_mixer_pkg;

    // Rounded amplitude * sin(pi*(2*idx+1)/(4*quarter_len)), computed with a
    // 2^30 fixed-point Taylor series so that elaboration needs no real math.
    function automatic int quarter_sin(input int idx, input int quarter_len, input int amp);
        longint pi_fx;
        longint theta;
        longint t2;
        longint term;
        longint sum;
        pi_fx = 64'sd3373259426;
        theta = (pi_fx * longint'(2 * idx + 1)) / longint'(4 * quarter_len);
        t2    = (theta * theta) >>> 30;
        term  = theta;
        sum   = theta;
        for (int k = 1; k < 10; k++) begin
            term = -(((term * t2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            sum  = sum + term;
        end
        return int'((longint'(amp) * sum + (64'sd1 <<< 29)) >>> 30);
    endfunction

    // Quadrant of a table address: bit 0 mirrors the index, bit 1 negates.
    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_RISE = 2'd2,
        QD_NEG_FALL = 2'd3
    } quadrant_e;

endpackage

// File: rtl/iq_phase_acc.sv
module iq_phase_acc #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase,
    output logic [ADDR_W-1:0]  addr
);

    logic [PHASE_W-1:0] acc_d;
    logic [PHASE_W-1:0] acc_q;

    always_comb begin
        acc_d = acc_q;
        if (step_en) begin
            acc_d = acc_q + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase = acc_q;
    assign addr  = acc_q[PHASE_W-1 -: ADDR_W];

endmodule

// File: rtl/iq_sine_rom.sv
module iq_sine_rom
    import iq_mixer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] sin_val,
    output logic signed [AMP_W-1:0] cos_val
);

    localparam int IDX_W   = ADDR_W - 2;
    localparam int QLEN    = 1 << IDX_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(QLEN);

    logic signed [AMP_W-1:0] tbl [QLEN];

    generate
        for (genvar j = 0; j < QLEN; j++) begin : g_tbl
            localparam int VAL = quarter_sin(j, QLEN, AMP_MAX);
            assign tbl[j] = AMP_W'(VAL);
        end
    endgenerate

    logic [ADDR_W-1:0]       port_addr [2];
    logic signed [AMP_W-1:0] port_val  [2];

    assign port_addr[0] = addr;
    assign port_addr[1] = addr + QUARTER;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_port
            quadrant_e           quad;
            logic [IDX_W-1:0]    idx;
            logic [IDX_W-1:0]    fold;
            logic signed [AMP_W-1:0] mag;
            always_comb begin
                quad = quadrant_e'(port_addr[p][ADDR_W-1 -: 2]);
                idx  = port_addr[p][IDX_W-1:0];
                fold = (quad == QD_FALL || quad == QD_NEG_FALL) ? ~idx : idx;
                mag  = tbl[fold];
                port_val[p] = (quad == QD_NEG_RISE || quad == QD_NEG_FALL) ? -mag : mag;
            end
        end
    endgenerate

    assign sin_val = port_val[0];
    assign cos_val = port_val[1];

endmodule

// File: rtl/iq_front_stage.sv
module iq_front_stage #(
    parameter int SAMPLE_W = 6,
    parameter int AMP_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [SAMPLE_W-1:0]        in_sample,
    input  logic                       in_neg,
    input  logic signed [AMP_W-1:0]    sin_val,
    input  logic signed [AMP_W-1:0]    cos_val,
    output logic                       st_valid,
    output logic                       st_neg,
    output logic signed [SAMPLE_W-1:0] st_sample,
    output logic signed [AMP_W-1:0]    st_sin,
    output logic signed [AMP_W-1:0]    st_cos
);

    typedef struct packed {
        logic                       vld;
        logic                       neg;
        logic signed [SAMPLE_W-1:0] smp;
        logic signed [AMP_W-1:0]    sn;
        logic signed [AMP_W-1:0]    cs;
    } front_t;

    front_t fr_d;
    front_t fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.vld = in_valid;
        if (in_valid) begin
            fr_d.neg = in_neg;
            fr_d.smp = {~in_sample[SAMPLE_W-1], in_sample[SAMPLE_W-2:0]};
            fr_d.sn  = sin_val;
            fr_d.cs  = cos_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign st_valid  = fr_q.vld;
    assign st_neg    = fr_q.neg;
    assign st_sample = fr_q.smp;
    assign st_sin    = fr_q.sn;
    assign st_cos    = fr_q.cs;

endmodule

// File: rtl/iq_mix_stage.sv
module iq_mix_stage #(
    parameter int SAMPLE_W = 6,
    parameter int AMP_W    = 8,
    parameter int PROD_W   = SAMPLE_W + AMP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       st_valid,
    input  logic                       st_neg,
    input  logic signed [SAMPLE_W-1:0] st_sample,
    input  logic signed [AMP_W-1:0]    st_sin,
    input  logic signed [AMP_W-1:0]    st_cos,
    output logic                       out_valid,
    output logic signed [PROD_W-1:0]   out_i,
    output logic signed [PROD_W-1:0]   out_q
);

    typedef struct packed {
        logic                     vld;
        logic signed [PROD_W-1:0] pi;
        logic signed [PROD_W-1:0] pq;
    } mix_t;

    mix_t mx_d;
    mix_t mx_q;

    logic signed [PROD_W-1:0] smp_x;
    logic signed [PROD_W-1:0] sin_x;
    logic signed [PROD_W-1:0] cos_x;
    logic signed [PROD_W-1:0] raw_q;

    always_comb begin
        smp_x    = PROD_W'(st_sample);
        sin_x    = PROD_W'(st_sin);
        cos_x    = PROD_W'(st_cos);
        raw_q    = smp_x * sin_x;
        mx_d     = mx_q;
        mx_d.vld = st_valid;
        if (st_valid) begin
            mx_d.pi = smp_x * cos_x;
            mx_d.pq = st_neg ? -raw_q : raw_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mx_q <= '0;
        end else begin
            mx_q <= mx_d;
        end
    end

    assign out_valid = mx_q.vld;
    assign out_i     = mx_q.pi;
    assign out_q     = mx_q.pq;

endmodule

// File: rtl/iq_mixer.sv
module iq_mixer #(
    parameter int SAMPLE_W = 6,
    parameter int PHASE_W  = 24,
    parameter int ADDR_W   = 8,
    parameter int AMP_W    = 8,
    parameter int PROD_W   = SAMPLE_W + AMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [SAMPLE_W-1:0]      in_sample,
    input  logic [PHASE_W-1:0]       phase_inc,
    input  logic                     q_negate,
    output logic                     out_valid,
    output logic signed [PROD_W-1:0] out_i,
    output logic signed [PROD_W-1:0] out_q
);

    logic [PHASE_W-1:0]        phase_q;
    logic [ADDR_W-1:0]         lut_addr;
    logic signed [AMP_W-1:0]   sin_val;
    logic signed [AMP_W-1:0]   cos_val;
    logic                      st_valid;
    logic                      st_neg;
    logic signed [SAMPLE_W-1:0] st_sample;
    logic signed [AMP_W-1:0]   st_sin;
    logic signed [AMP_W-1:0]   st_cos;

    iq_phase_acc #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_en (in_valid),
        .step    (phase_inc),
        .phase   (phase_q),
        .addr    (lut_addr)
    );

    iq_sine_rom #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_rom (
        .addr    (lut_addr),
        .sin_val (sin_val),
        .cos_val (cos_val)
    );

    iq_front_stage #(
        .SAMPLE_W (SAMPLE_W),
        .AMP_W    (AMP_W)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_neg    (q_negate),
        .sin_val   (sin_val),
        .cos_val   (cos_val),
        .st_valid  (st_valid),
        .st_neg    (st_neg),
        .st_sample (st_sample),
        .st_sin    (st_sin),
        .st_cos    (st_cos)
    );

    iq_mix_stage #(
        .SAMPLE_W (SAMPLE_W),
        .AMP_W    (AMP_W),
        .PROD_W   (PROD_W)
    ) u_mix (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_neg    (st_neg),
        .st_sample (st_sample),
        .st_sin    (st_sin),
        .st_cos    (st_cos),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: rtl/iq_mixer_chk.sv
module iq_mixer_chk #(
    parameter int SAMPLE_W = 6,
    parameter int PHASE_W  = 24,
    parameter int AMP_W    = 8,
    parameter int PROD_W   = SAMPLE_W + AMP_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [SAMPLE_W-1:0]      in_sample,
    input logic [PHASE_W-1:0]       phase_inc,
    input logic                     out_valid,
    input logic signed [PROD_W-1:0] out_i,
    input logic signed [PROD_W-1:0] out_q,
    input logic [PHASE_W-1:0]       phase
);

    localparam int MAX_MAG = (1 << (SAMPLE_W - 1)) * ((1 << (AMP_W - 1)) - 1);
    localparam logic [SAMPLE_W-1:0] ZERO_CODE = SAMPLE_W'(1 << (SAMPLE_W - 1));

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid); // R9

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 ($stable(out_i) && $stable(out_q))); // R9

    AST_ZERO_CODE_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample == ZERO_CODE) |=> ##1 (out_i == '0 && out_q == '0)); // R1

    AST_PRODUCT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_i) <= MAX_MAG && int'(out_i) >= -MAX_MAG
                    && int'(out_q) <= MAX_MAG && int'(out_q) >= -MAX_MAG)); // R2

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase)); // R5

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (phase == PHASE_W'($past(phase) + $past(phase_inc)))); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (phase == '0 && !out_valid && out_i == '0 && out_q == '0)); // R10

endmodule

bind iq_mixer iq_mixer_chk #(
    .SAMPLE_W (SAMPLE_W),
    .PHASE_W  (PHASE_W),
    .AMP_W    (AMP_W),
    .PROD_W   (PROD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .phase_inc (phase_inc),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .phase     (phase_q)
);

// File: tb/iq_mixer_bench.sv
module iq_mixer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_sample = 6'd0;
    logic [23:0] phase_inc = 24'd0;
    logic        q_negate = 1'b0;
    logic        out_valid;
    logic signed [13:0] out_i;
    logic signed [13:0] out_q;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    ei;
        int    eq;
        string tag;
    } exp_t;

    exp_t        expq[$];
    logic [23:0] model_ph = 24'd0;

    always #5 clk = ~clk;

    iq_mixer u_iq_mixer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .phase_inc (phase_inc),
        .q_negate  (q_negate),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    function automatic int lut(input int a);
        real r;
        r = 127.0 * $sin(2.0 * 3.14159265358979 * (real'(a % 256) + 0.5) / 256.0);
        return int'($floor(r + 0.5));
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Monitor: every output strobe is compared with the next expected pair.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 actual=unexpected out_valid expected=no output");
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " I"}, int'(out_i), e.ei);
                check({e.tag, " Q"}, int'(out_q), e.eq);
            end
        end
    end

    // Present one sample at the falling edge; returns one falling edge later.
    task automatic push(input int code, input bit neg, input string tag);
        exp_t e;
        int   a;
        int   s;
        a = int'(model_ph[23:16]);
        s = code - 32;
        e.ei = s * lut(a + 64);
        e.eq = neg ? -(s * lut(a)) : s * lut(a);
        e.tag = tag;
        expq.push_back(e);
        model_ph = model_ph + phase_inc;
        in_valid  = 1'b1;
        in_sample = 6'(code);
        q_negate  = neg;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 6'd63;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("R10 out_valid in reset", int'(out_valid), 0);
        check("R10 out_i in reset", int'(out_i), 0);
        check("R10 out_q in reset", int'(out_q), 0);
        rst = 1'b0;
        model_ph = 24'd0;
        expq.delete();
        @(negedge clk);
    endtask

    task automatic t_latency_first();
        phase_inc = 24'h123456;
        idle(2);
        push(63, 1'b0, "R7 first sample");
        in_valid = 1'b0;
        check("R9 no output after one clock", int'(out_valid), 0);
        @(negedge clk);
        check("R9 output after two clocks", int'(out_valid), 1);
        check("R7 phase zero I", int'(out_i), 31 * 127);
        check("R7 phase zero Q", int'(out_q), 31 * 2);
        idle(3);
    endtask

    task automatic t_offset();
        phase_inc = 24'd0;
        push(0,  1'b0, "R1 code 0");
        push(32, 1'b0, "R1 code 32");
        push(63, 1'b0, "R1 code 63");
        push(1,  1'b0, "R1 code 1");
        idle(3);
    endtask

    task automatic t_sweep();
        phase_inc = 24'h010000;
        for (int k = 0; k < 256; k++) begin
            push((k % 2 == 0) ? 63 : 0, 1'b0, "R8 table sweep");
        end
        phase_inc = 24'h0A3D71;
        for (int k = 0; k < 40; k++) begin
            push((k * 13 + 5) % 64, 1'b0, "R2 R3 mixed");
        end
        idle(3);
    endtask

    task automatic t_negate();
        phase_inc = 24'h05A000;
        for (int k = 0; k < 30; k++) begin
            push((k * 7 + 3) % 64, k[0], "R4 negate");
        end
        q_negate = 1'b0;
        idle(3);
    endtask

    task automatic t_gap_hold();
        logic signed [13:0] held_i;
        logic signed [13:0] held_q;
        for (int k = 0; k < 10; k++) begin
            phase_inc = 24'h031000 + 24'(k * 24'h001F00);
            push((k * 11 + 9) % 64, 1'b0, "R5 gap");
            in_valid = 1'b0;
            phase_inc = 24'h7F0000;
            repeat (k % 3 + 1) @(negedge clk);
        end
        idle(3);
        held_i = out_i;
        held_q = out_q;
        phase_inc = 24'h400000;
        idle(5);
        check("R9 hold I", int'(out_i), int'(held_i));
        check("R9 hold Q", int'(out_q), int'(held_q));
    endtask

    task automatic t_wrap();
        phase_inc = 24'hFFFFFF;
        for (int k = 0; k < 8; k++) push(50, 1'b0, "R6 wrap down");
        phase_inc = 24'h800001;
        for (int k = 0; k < 8; k++) push(10, 1'b1, "R6 wrap half");
        phase_inc = 24'hF3A000;
        for (int k = 0; k < 30; k++) push(60, 1'b0, "R6 wrap large");
        idle(4);
        check("R9 all samples produced", expq.size(), 0);
    endtask

    task automatic t_reset_mid();
        phase_inc = 24'h222222;
        push(40, 1'b0, "R10 pre");
        push(41, 1'b0, "R10 pre");
        idle(3);
        t_reset();
        phase_inc = 24'h111111;
        push(20, 1'b0, "R10 phase cleared");
        idle(3);
    endtask

    initial begin
        t_reset();
        t_latency_first();
        t_offset();
        t_sweep();
        t_negate();
        t_gap_hold();
        t_wrap();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule